// File: doc/BRIEF.md
# Round-Robin Thread Context Sequencer

This block decides which of four hardware threads owns each fetch slot of a five-stage in-order pipeline that the threads share. A 2-bit slot pointer advances by one every cycle with no stall input, so each thread issues exactly once every four cycles. For the selected thread the block presents its program counter, its ID and a valid bit. A thread that has finished keeps its slot, but the valid bit is low, so the slot travels down the pipeline as a bubble and the other threads keep their timing.

With four threads and five stages, the instruction in writeback always belongs to the thread being fetched in the same cycle. The block takes the retiring instruction's resolved next PC, a terminate flag and a thread-ID-read request. It forwards the next PC straight to fetch, updates the thread's stored PC and live flag, and gates the register-file and flag write enables. A terminated thread's PC holds the address after the terminating instruction and never changes again. A sticky halt rises once all four threads have terminated.

Top module: `barrel_ctx_seq`

## Requirements
- R1: While rst_n is low and just after it rises, fetch_tid is 0, fetch_pc is 0x0040_0000 for every thread's slot, fetch_valid is 1 and halt is 0.
- R2: fetch_tid steps 0, 1, 2, 3, 0, … on every clock edge out of reset. No input can hold it.
- R3: When a live thread retires (wb_valid=1, wb_tid equal to fetch_tid), fetch_pc shows wb_next_pc in that same cycle. Otherwise fetch_pc is the thread's stored PC, which is the next PC of its last retired instruction.
- R4: A live retirement with wb_term=1 stores wb_next_pc (the address after the terminating instruction) as that thread's final PC and clears its live flag. In that cycle and in every later slot of that thread, fetch_valid is 0 and fetch_pc shows the final PC.
- R5: A retirement from an already terminated thread changes neither its PC nor its live state.
- R6: rf_we equals wb_rf_req and flag_we equals wb_flag_req only for a live retirement without wb_term. In every other case both are 0.
- R7: A live retirement with wb_tid_req=1 and no wb_term asserts tid_we, and tid_data carries wb_tid zero-extended to DATA_W bits.
- R8: halt rises on the edge where the last live thread terminates, not earlier. It then stays high until reset, and while it is high fetch_valid is 0.
- R9: A cycle with wb_valid=0 asserts no write enable and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_tid | output | TID_W (2) | Thread owning this cycle's fetch slot |
| fetch_pc | output | PC_W (32) | Address to fetch for that thread |
| fetch_valid | output | 1 | 0 marks the slot as a bubble |
| wb_valid | input | 1 | An instruction retires this cycle |
| wb_tid | input | TID_W (2) | Thread of the retiring instruction |
| wb_next_pc | input | PC_W (32) | Resolved next PC of the retiring instruction |
| wb_term | input | 1 | Retiring instruction ends its thread |
| wb_tid_req | input | 1 | Retiring instruction reads its thread ID into R0 |
| wb_rf_req | input | 1 | Retiring instruction wants a register write |
| wb_flag_req | input | 1 | Retiring instruction wants a flag write |
| rf_we | output | 1 | Gated register-file write enable |
| flag_we | output | 1 | Gated flag write enable |
| tid_we | output | 1 | Write the thread ID into R0 |
| tid_data | output | DATA_W (32) | Zero-extended thread ID |
| halt | output | 1 | All threads terminated (sticky) |

## Verification
The bench targets the same-cycle forwarding of the retiring next PC. A design that fetched from the stored PC would replay the old instruction once per round. A terminate arriving in the thread's own slot must already bubble that slot, and a design that missed this would issue one extra instruction after the end. Retirements aimed at dead threads and bubbles that still carry write requests check that dead state stays frozen and that no write escapes the gating. The bench also checks that halt rises exactly one edge after the last terminate, no earlier, and clears only on reset.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
   // Control bits carried by a retiring instruction.
   typedef struct packed {
      logic valid;
      logic term;
      logic tid_req;
      logic rf_req;
      logic flag_req;
   } retire_ctl_t;
endpackage

// File: rtl/ctx_rr_ptr.sv
module ctx_rr_ptr #(
   parameter int N_THREADS = 4,
   localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TID_W-1:0] cur
);
   generate
      if (N_THREADS == (1 << TID_W)) begin : g_pow2
         // Natural wrap of the counter gives the rotation.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= '0;
            else        cur <= cur + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               cur <= '0;
            else if (cur == TID_W'(N_THREADS - 1))    cur <= '0;
            else                                      cur <= cur + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ctx_state_bank.sv
module ctx_state_bank #(
   parameter int          N_THREADS = 4,
   parameter int          PC_W      = 32,
   parameter logic [31:0] RESET_PC  = 32'h0040_0000,
   localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_en,
   input  logic [TID_W-1:0]          upd_tid,
   input  logic [PC_W-1:0]           upd_pc,
   input  logic                      upd_kill,
   output logic [N_THREADS*PC_W-1:0] pc_flat,
   output logic [N_THREADS-1:0]      live
);
   generate
      for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
         logic            sel;
         logic [PC_W-1:0] pc_q;
         assign sel = upd_en && (upd_tid == TID_W'(g)) && live[g];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q    <= PC_W'(RESET_PC);
               live[g] <= 1'b1;
            end else if (sel) begin
               pc_q <= upd_pc;
               if (upd_kill) live[g] <= 1'b0;
            end
         end
         assign pc_flat[g*PC_W +: PC_W] = pc_q;
      end
   endgenerate
endmodule

// File: rtl/ctx_we_gate.sv
module ctx_we_gate
   import ctx_seq_pkg::*;
#(
   parameter int TID_W  = 2,
   parameter int DATA_W = 32
) (
   input  retire_ctl_t        ctl,
   input  logic               thr_live,
   input  logic [TID_W-1:0]   tid,
   output logic               rf_we,
   output logic               flag_we,
   output logic               tid_we,
   output logic [DATA_W-1:0]  tid_data
);
   logic commit;
   // Only a live, non-terminating retirement may write anything.
   assign commit   = ctl.valid && thr_live && !ctl.term;
   assign rf_we    = commit && ctl.rf_req;
   assign flag_we  = commit && ctl.flag_req;
   assign tid_we   = commit && ctl.tid_req;
   assign tid_data = DATA_W'(tid);
endmodule

// File: rtl/barrel_ctx_seq.sv
module barrel_ctx_seq
   import ctx_seq_pkg::*;
#(
   parameter int          N_THREADS = 4,
   parameter int          PC_W      = 32,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] RESET_PC  = 32'h0040_0000,
   localparam int TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TID_W-1:0]  fetch_tid,
   output logic [PC_W-1:0]   fetch_pc,
   output logic              fetch_valid,
   input  logic              wb_valid,
   input  logic [TID_W-1:0]  wb_tid,
   input  logic [PC_W-1:0]   wb_next_pc,
   input  logic              wb_term,
   input  logic              wb_tid_req,
   input  logic              wb_rf_req,
   input  logic              wb_flag_req,
   output logic              rf_we,
   output logic              flag_we,
   output logic              tid_we,
   output logic [DATA_W-1:0] tid_data,
   output logic              halt
);
   generate
      if (N_THREADS < 2)          begin : g_bad_n  $error("N_THREADS must be at least 2"); end
      if (PC_W < 2 || PC_W > 32)  begin : g_bad_pc $error("PC_W must lie in 2..32");      end
      if (DATA_W < TID_W)         begin : g_bad_dw $error("DATA_W narrower than thread ID"); end
   endgenerate

   logic [N_THREADS*PC_W-1:0] pc_flat;
   logic [N_THREADS-1:0]      live;
   logic [N_THREADS-1:0]      live_after;
   logic [N_THREADS-1:0]      kill_mask;
   logic                      retire;
   logic                      hit;
   logic [PC_W-1:0]           slot_pc;
   retire_ctl_t               ctl;

   assign ctl = '{valid: wb_valid, term: wb_term, tid_req: wb_tid_req,
                  rf_req: wb_rf_req, flag_req: wb_flag_req};

   ctx_rr_ptr #(.N_THREADS(N_THREADS)) u_ptr (
      .clk (clk), .rst_n (rst_n), .cur (fetch_tid)
   );

   ctx_state_bank #(
      .N_THREADS(N_THREADS), .PC_W(PC_W), .RESET_PC(RESET_PC)
   ) u_bank (
      .clk (clk), .rst_n (rst_n),
      .upd_en (wb_valid), .upd_tid (wb_tid), .upd_pc (wb_next_pc),
      .upd_kill (wb_term), .pc_flat (pc_flat), .live (live)
   );

   ctx_we_gate #(.TID_W(TID_W), .DATA_W(DATA_W)) u_gate (
      .ctl (ctl), .thr_live (live[wb_tid]), .tid (wb_tid),
      .rf_we (rf_we), .flag_we (flag_we), .tid_we (tid_we), .tid_data (tid_data)
   );

   // Writeback and fetch share a thread: forward the resolved PC.
   assign retire      = wb_valid && live[wb_tid];
   assign hit         = retire && (wb_tid == fetch_tid);
   assign slot_pc     = pc_flat[fetch_tid*PC_W +: PC_W];
   assign fetch_pc    = hit ? wb_next_pc : slot_pc;
   assign fetch_valid = live[fetch_tid] && !(hit && wb_term);

   assign kill_mask  = (retire && wb_term) ? (N_THREADS'(1) << wb_tid) : '0;
   assign live_after = live & ~kill_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt <= 1'b0;
      else        halt <= halt || (live_after == '0);
   end
endmodule

// File: rtl/barrel_ctx_seq_chk.sv
module barrel_ctx_seq_chk #(
   parameter int N_THREADS = 4,
   parameter int PC_W      = 32,
   parameter int DATA_W    = 32,
   parameter int TID_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TID_W-1:0]  fetch_tid,
   input logic              fetch_valid,
   input logic              wb_valid,
   input logic [TID_W-1:0]  wb_tid,
   input logic              wb_term,
   input logic              rf_we,
   input logic              flag_we,
   input logic              tid_we,
   input logic [DATA_W-1:0] tid_data,
   input logic              halt
);
   a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> fetch_tid == (($past(fetch_tid) == TID_W'(N_THREADS - 1)) ?
                              TID_W'(0) : TID_W'($past(fetch_tid) + 1'b1)));

   a_r4_term_bubbles_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_term && wb_tid == fetch_tid) |-> !fetch_valid);

   a_r9_bubble_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_valid |-> (!rf_we && !flag_we && !tid_we));

   a_r6_term_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      wb_term |-> (!rf_we && !flag_we && !tid_we));

   a_r7_tid_value: assert property (@(posedge clk) disable iff (!rst_n)
      tid_we |-> tid_data == DATA_W'(wb_tid));

   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);

   a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (!fetch_valid && !rf_we && !flag_we && !tid_we));
endmodule

bind barrel_ctx_seq barrel_ctx_seq_chk #(
   .N_THREADS(N_THREADS), .PC_W(PC_W), .DATA_W(DATA_W), .TID_W(TID_W)
) u_chk (
   .clk (clk), .rst_n (rst_n), .fetch_tid (fetch_tid), .fetch_valid (fetch_valid),
   .wb_valid (wb_valid), .wb_tid (wb_tid), .wb_term (wb_term),
   .rf_we (rf_we), .flag_we (flag_we), .tid_we (tid_we),
   .tid_data (tid_data), .halt (halt)
);

// File: tb/barrel_ctx_seq_bench.sv
`timescale 1ns/1ps
module barrel_ctx_seq_bench;
   localparam logic [31:0] RST_PC = 32'h0040_0000;
   // Stimulus bits: {valid, term, tid_req, rf_req, flag_req, branch}
   localparam logic [5:0] STIM [16] = '{
      6'b100100, 6'b101000, 6'b100011, 6'b110000,
      6'b110000, 6'b100110, 6'b000100, 6'b100100,
      6'b110000, 6'b110000, 6'b101100, 6'b000000,
      6'b000000, 6'b100100, 6'b110000, 6'b000000 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fetch_tid;
   logic [31:0] fetch_pc;
   logic        fetch_valid;
   logic        wb_valid = 0, wb_term = 0, wb_tid_req = 0, wb_rf_req = 0, wb_flag_req = 0;
   logic [1:0]  wb_tid = '0;
   logic [31:0] wb_next_pc = '0;
   logic        rf_we, flag_we, tid_we, halt;
   logic [31:0] tid_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] mpc [4];
   logic        malive [4];
   logic        mhalt;

   always #2.5 clk = ~clk;

   barrel_ctx_seq u_barrel_ctx_seq (
      .clk (clk), .rst_n (rst_n), .fetch_tid (fetch_tid), .fetch_pc (fetch_pc),
      .fetch_valid (fetch_valid), .wb_valid (wb_valid), .wb_tid (wb_tid),
      .wb_next_pc (wb_next_pc), .wb_term (wb_term), .wb_tid_req (wb_tid_req),
      .wb_rf_req (wb_rf_req), .wb_flag_req (wb_flag_req), .rf_we (rf_we),
      .flag_we (flag_we), .tid_we (tid_we), .tid_data (tid_data), .halt (halt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wb_valid = 0; wb_term = 0; wb_tid_req = 0; wb_rf_req = 0; wb_flag_req = 0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin mpc[i] = RST_PC; malive[i] = 1'b1; end
      mhalt = 1'b0;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R1 tid in reset", 32'(fetch_tid), 0);
      chk("R1 pc in reset", fetch_pc, RST_PC);
      chk("R1 valid in reset", 32'(fetch_valid), 1);
      chk("R1 halt in reset", 32'(halt), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R2 R3 R4 R5 R6 R7 R9
      for (int k = 0; k < 16; k++) begin
         logic [5:0]  s;
         logic [1:0]  t;
         logic [31:0] nxt;
         logic        ret;
         s   = STIM[k];
         t   = 2'(k % 4);
         nxt = mpc[t] + (s[0] ? 32'h100 : 32'h4);
         ret = s[5] && malive[t];
         wb_valid = s[5]; wb_term = s[4]; wb_tid_req = s[3];
         wb_rf_req = s[2]; wb_flag_req = s[1];
         wb_tid = t; wb_next_pc = nxt;
         #1;
         chk("R2 slot order", 32'(fetch_tid), 32'(t));
         chk("R3 R5 fetch pc", fetch_pc, ret ? nxt : mpc[t]);
         chk("R4 slot valid", 32'(fetch_valid), 32'(malive[t] && !(ret && s[4])));
         chk("R6 R9 rf_we", 32'(rf_we), 32'(ret && !s[4] && s[2]));
         chk("R6 R9 flag_we", 32'(flag_we), 32'(ret && !s[4] && s[1]));
         chk("R7 tid_we", 32'(tid_we), 32'(ret && !s[4] && s[3]));
         if (tid_we) chk("R7 tid_data", tid_data, 32'(t));
         chk("R8 halt timing", 32'(halt), 32'(mhalt));
         @(posedge clk);
         if (ret) begin
            mpc[t] = nxt;
            if (s[4]) malive[t] = 1'b0;
         end
         mhalt = mhalt || !(malive[0] || malive[1] || malive[2] || malive[3]);
         @(negedge clk);
      end

      // R8/R5: halted, retires to dead threads are ignored
      for (int k = 0; k < 8; k++) begin
         wb_valid = 1; wb_rf_req = 1; wb_term = k[0];
         wb_tid = fetch_tid; wb_next_pc = 32'hDEAD_0000;
         #1;
         chk("R8 halt sticky", 32'(halt), 1);
         chk("R8 no fetch after halt", 32'(fetch_valid), 0);
         chk("R5 frozen pc", fetch_pc, mpc[fetch_tid]);
         chk("R6 dead write", 32'(rf_we), 0);
         @(negedge clk);
      end
      idle_inputs();
      chk("R4 final pc t0", mpc[0], RST_PC + 8);

      // R1: reset mid-run restores everything
      rst_n = 1'b0;
      #1;
      chk("R1 halt cleared", 32'(halt), 0);
      chk("R1 tid cleared", 32'(fetch_tid), 0);
      chk("R1 pc restored", fetch_pc, RST_PC);
      chk("R1 slot live", 32'(fetch_valid), 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R2 first step", 32'(fetch_tid), 1);
      chk("R1 thread1 pc", fetch_pc, RST_PC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule